// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block connects a 32-bit load/store datapath to a word-wide data memory whose bytes each have their own address. On a store it takes an access size (byte, half-word or word), a byte address and the store operand. It drives the word index, one write enable per byte lane, and write data with the operand placed in the lanes that the address selects. On a load it takes the 32-bit word read from memory and returns the addressed byte, half-word or word. Byte and half-word results are widened to 32 bits, either zero-extended or sign-extended.

Memory is little-endian: lane 0 carries bits 7:0 of the word and holds the byte whose address has bits 1:0 equal to 0. Any access whose address is not a multiple of its size raises a fault flag in the same cycle. A faulting access writes nothing and reads back zero. A parameter adds an optional output register, which delays all outputs by exactly one clock.

Top module: `mem_lane_aligner`

## Requirements
- R1: The word index output equals byte address bits 31:2.
- R2: A byte store (size code 2'b00) asserts only the enable for lane address[1:0]. The operand's low byte is copied into all four lanes of the write data.
- R3: A half-word store (size code 2'b01) asserts enables 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. The operand's low 16 bits are copied into both halves of the write data.
- R4: A word store (size code 2'b10) with address bits 1:0 equal to 0 asserts enables 4'b1111 and passes the operand through unchanged.
- R5: The fault flag rises when the request is valid and the access is misaligned. A byte access is never misaligned. A half-word access is misaligned when address bit 0 is 1. A word access is misaligned when address bits 1:0 are not 0. Size code 2'b11 always counts as misaligned.
- R6: During a fault, all byte enables are 0 and the load result is 0.
- R7: A byte load returns bits 8*a+7:8*a of the memory word, where a is address bits 1:0.
- R8: A half-word load returns memory bits 15:0 when address bit 1 is 0 and bits 31:16 when it is 1.
- R9: When the unsigned input is 1, byte and half-word loads are zero-extended. When it is 0, they are sign-extended from the top bit of the selected item. A word load returns the memory word unchanged.
- R10: When the request is not valid, or is a load (write input 0), no byte enable is asserted. When the request is not valid, no fault is raised.
- R11: With the output register enabled, every output shows the result for the inputs present at the previous rising clock edge. During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store operand, right-aligned |
| req_unsigned | input | 1 | 1 = zero-extend sub-word loads, 0 = sign-extend |
| mem_rdata | input | 32 | Word read from memory |
| mem_word_addr | output | ADDR_W-2 | Word index to memory |
| mem_be | output | 4 | Byte-lane write enables, bit n = lane n |
| mem_wdata | output | 32 | Lane-steered write data |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Alignment fault for the current access |

## Verification
The assertions assume that the request fields are stable and known during each cycle in which `req_valid` is high. They also assume that `mem_rdata` already holds the word addressed by the current request, with no memory latency between the two. The stimulus changes inputs only at falling edges and holds every field at a defined value, including the data fields of idle and misaligned requests. For the registered variant, the memory word is presented in the same cycle as its request, which matches the one-cycle behaviour the latency check expects.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned LANE_W   = 8;
    localparam int unsigned N_LANES  = WORD_W / LANE_W;
    localparam int unsigned HALF_W   = 2 * LANE_W;
    localparam int unsigned LANE_SEL = $clog2(N_LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [N_LANES-1:0] be;
        logic [WORD_W-1:0]  wdata;
    } st_beat_t;

    typedef struct packed {
        logic [N_LANES-1:0] be;
        logic [WORD_W-1:0]  wdata;
        logic [WORD_W-1:0]  rdata;
        logic               fault;
    } lane_result_t;

    function automatic logic [WORD_W-1:0] widen_byte(input logic [LANE_W-1:0] b,
                                                     input logic uns);
        return {{(WORD_W-LANE_W){b[LANE_W-1] & ~uns}}, b};
    endfunction

    function automatic logic [WORD_W-1:0] widen_half(input logic [HALF_W-1:0] h,
                                                     input logic uns);
        return {{(WORD_W-HALF_W){h[HALF_W-1] & ~uns}}, h};
    endfunction

endpackage

// File: rtl/align_check.sv
module align_check
    import lane_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  acc_size_e           size,
    input  logic [LANE_SEL-1:0] lo,
    output logic                bad
);

    always_comb begin
        unique case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = lo[0];
            SZ_WORD: bad = |lo;
            default: bad = 1'b1;
        endcase
    end

    AST_HALF_ODD_BAD: assert property (@(posedge clk) disable iff (rst)
        (size == SZ_HALF && lo[0]) |-> bad); // R5
    AST_BYTE_NEVER_BAD: assert property (@(posedge clk) disable iff (rst)
        (size == SZ_BYTE) |-> !bad); // R5
    AST_WORD_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (size == SZ_WORD && lo != '0) |-> bad); // R5

endmodule

// File: rtl/store_steer.sv
module store_steer
    import lane_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  acc_size_e           size,
    input  logic [LANE_SEL-1:0] lo,
    input  logic [WORD_W-1:0]   opnd,
    output st_beat_t            beat
);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic hit;
        always_comb begin
            unique case (size)
                SZ_BYTE: hit = (lo == LANE_SEL'(g));
                SZ_HALF: hit = (lo[1] == g[1]);
                default: hit = 1'b1;
            endcase
            beat.be[g] = en & hit;
        end

        always_comb begin
            unique case (size)
                SZ_BYTE: beat.wdata[g*LANE_W +: LANE_W] = opnd[LANE_W-1:0];
                SZ_HALF: beat.wdata[g*LANE_W +: LANE_W] = opnd[(g%2)*LANE_W +: LANE_W];
                default: beat.wdata[g*LANE_W +: LANE_W] = opnd[g*LANE_W +: LANE_W];
            endcase
        end
    end

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        (en && size == SZ_BYTE) |-> ($countones(beat.be) == 1)); // R2
    AST_HALF_PAIR: assert property (@(posedge clk) disable iff (rst)
        (en && size == SZ_HALF) |-> (beat.be == 4'b0011 || beat.be == 4'b1100)); // R3
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |-> (beat.be == '0)); // R6

endmodule

// File: rtl/load_extract.sv
module load_extract
    import lane_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                kill,
    input  acc_size_e           size,
    input  logic [LANE_SEL-1:0] lo,
    input  logic                uns,
    input  logic [WORD_W-1:0]   word,
    output logic [WORD_W-1:0]   result
);

    logic [LANE_W-1:0] lanes [N_LANES];
    logic [HALF_W-1:0] half_sel;

    for (genvar g = 0; g < N_LANES; g++) begin : g_split
        assign lanes[g] = word[g*LANE_W +: LANE_W];
    end

    assign half_sel = lo[1] ? word[WORD_W-1 -: HALF_W] : word[HALF_W-1:0];

    always_comb begin
        if (kill) begin
            result = '0;
        end else begin
            unique case (size)
                SZ_BYTE: result = widen_byte(lanes[lo], uns);
                SZ_HALF: result = widen_half(half_sel, uns);
                default: result = word;
            endcase
        end
    end

    AST_KILL_ZERO: assert property (@(posedge clk) disable iff (rst)
        kill |-> (result == '0)); // R6
    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (!kill && uns && size == SZ_BYTE) |-> (result[WORD_W-1:LANE_W] == '0)); // R9
    AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (!kill && uns && size == SZ_HALF) |-> (result[WORD_W-1:HALF_W] == '0)); // R9

endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner
    import lane_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter bit          REG_OUT = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_we,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [31:0]         req_wdata,
    input  logic                req_unsigned,
    input  logic [31:0]         mem_rdata,
    output logic [ADDR_W-3:0]   mem_word_addr,
    output logic [3:0]          mem_be,
    output logic [31:0]         mem_wdata,
    output logic [31:0]         ld_data,
    output logic                misalign
);

    localparam int unsigned WIDX_W = ADDR_W - LANE_SEL;

    acc_size_e           size;
    logic [LANE_SEL-1:0] lo;
    logic                bad;
    logic                st_en;
    st_beat_t            beat;
    logic [WORD_W-1:0]   rd_ext;
    lane_result_t        nxt;
    logic [WIDX_W-1:0]   nxt_widx;

    assign size     = acc_size_e'(req_size);
    assign lo       = req_addr[LANE_SEL-1:0];
    assign nxt_widx = req_addr[ADDR_W-1:LANE_SEL];
    assign st_en    = req_valid & req_we & ~bad;

    align_check u_align (
        .clk  (clk),
        .rst  (rst),
        .size (size),
        .lo   (lo),
        .bad  (bad)
    );

    store_steer u_store (
        .clk  (clk),
        .rst  (rst),
        .en   (st_en),
        .size (size),
        .lo   (lo),
        .opnd (req_wdata),
        .beat (beat)
    );

    load_extract u_load (
        .clk    (clk),
        .rst    (rst),
        .kill   (bad),
        .size   (size),
        .lo     (lo),
        .uns    (req_unsigned),
        .word   (mem_rdata),
        .result (rd_ext)
    );

    always_comb begin
        nxt.be    = beat.be;
        nxt.wdata = beat.wdata;
        nxt.rdata = rd_ext;
        nxt.fault = req_valid & bad;
    end

    if (REG_OUT) begin : g_reg
        lane_result_t      q;
        logic [WIDX_W-1:0] q_widx;
        always_ff @(posedge clk) begin
            if (rst) begin
                q      <= '0;
                q_widx <= '0;
            end else begin
                q      <= nxt;
                q_widx <= nxt_widx;
            end
        end
        assign mem_word_addr = q_widx;
        assign mem_be        = q.be;
        assign mem_wdata     = q.wdata;
        assign ld_data       = q.rdata;
        assign misalign      = q.fault;

        AST_REG_LATENCY: assert property (@(posedge clk) disable iff (rst)
            !rst |=> (mem_be == $past(nxt.be))); // R11
    end else begin : g_comb
        assign mem_word_addr = nxt_widx;
        assign mem_be        = nxt.be;
        assign mem_wdata     = nxt.wdata;
        assign ld_data       = nxt.rdata;
        assign misalign      = nxt.fault;
    end

    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        nxt.fault |-> (nxt.be == '0)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!nxt.fault && nxt.be == '0)); // R10
    AST_LOAD_NO_BE: assert property (@(posedge clk) disable iff (rst)
        !req_we |-> (nxt.be == '0)); // R10

endmodule

// File: tb/mem_lane_aligner_test.sv
`timescale 1ns/1ps
module mem_lane_aligner_test;

    typedef struct packed {
        logic        we;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wd;
        logic        uns;
        logic [3:0]  ebe;
        logic [31:0] ewd;
        logic [31:0] erd;
        logic        flt;
        logic [7:0]  req;
    } vec_t;

    localparam logic [31:0] RWORD = 32'h80F1_7F82;
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 32'h1000_0003, 32'h1234_56AB, 1'b0, 4'b1000, 32'hABAB_ABAB, 32'h0, 1'b0, 8'd2}, // R2
        '{1'b1, 2'd0, 32'h1000_0000, 32'h1234_56CD, 1'b0, 4'b0001, 32'hCDCD_CDCD, 32'h0, 1'b0, 8'd2}, // R2
        '{1'b1, 2'd1, 32'h2000_0002, 32'h0000_BEEF, 1'b0, 4'b1100, 32'hBEEF_BEEF, 32'h0, 1'b0, 8'd3}, // R3
        '{1'b1, 2'd1, 32'h2000_0000, 32'hFFFF_1357, 1'b0, 4'b0011, 32'h1357_1357, 32'h0, 1'b0, 8'd3}, // R3
        '{1'b1, 2'd1, 32'h2000_0001, 32'h0000_1111, 1'b0, 4'b0000, 32'h0,         32'h0, 1'b1, 8'd5}, // R5
        '{1'b1, 2'd2, 32'h0000_0004, 32'hDEAD_BEEF, 1'b0, 4'b1111, 32'hDEAD_BEEF, 32'h0, 1'b0, 8'd4}, // R4
        '{1'b1, 2'd2, 32'h0000_0006, 32'hDEAD_BEEF, 1'b0, 4'b0000, 32'h0,         32'h0, 1'b1, 8'd5}, // R5
        '{1'b1, 2'd3, 32'h0000_0000, 32'h5555_5555, 1'b0, 4'b0000, 32'h0,         32'h0, 1'b1, 8'd5}, // R5
        '{1'b0, 2'd0, 32'h3000_0000, 32'h0,         1'b0, 4'b0000, 32'h0, 32'hFFFF_FF82, 1'b0, 8'd7}, // R7
        '{1'b0, 2'd0, 32'h3000_0001, 32'h0,         1'b0, 4'b0000, 32'h0, 32'h0000_007F, 1'b0, 8'd7}, // R7
        '{1'b0, 2'd0, 32'h3000_0002, 32'h0,         1'b1, 4'b0000, 32'h0, 32'h0000_00F1, 1'b0, 8'd9}, // R9
        '{1'b0, 2'd0, 32'h3000_0003, 32'h0,         1'b0, 4'b0000, 32'h0, 32'hFFFF_FF80, 1'b0, 8'd7}, // R7
        '{1'b0, 2'd1, 32'h3000_0000, 32'h0,         1'b0, 4'b0000, 32'h0, 32'h0000_7F82, 1'b0, 8'd8}, // R8
        '{1'b0, 2'd1, 32'h3000_0002, 32'h0,         1'b0, 4'b0000, 32'h0, 32'hFFFF_80F1, 1'b0, 8'd8}, // R8
        '{1'b0, 2'd1, 32'h3000_0002, 32'h0,         1'b1, 4'b0000, 32'h0, 32'h0000_80F1, 1'b0, 8'd9}, // R9
        '{1'b0, 2'd2, 32'hFFFF_FFF8, 32'h0,         1'b0, 4'b0000, 32'h0, 32'h80F1_7F82, 1'b0, 8'd9}, // R9
        '{1'b0, 2'd2, 32'h3000_0001, 32'h0,         1'b0, 4'b0000, 32'h0, 32'h0,         1'b1, 8'd6}, // R6
        '{1'b0, 2'd1, 32'h3000_0003, 32'h0,         1'b1, 4'b0000, 32'h0, 32'h0,         1'b1, 8'd6}  // R6
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_unsigned = 1'b0;
    logic [31:0] mem_rdata = RWORD;

    logic [29:0] c_widx, r_widx;
    logic [3:0]  c_be, r_be;
    logic [31:0] c_wd, r_wd, c_rd, r_rd;
    logic        c_flt, r_flt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    mem_lane_aligner #(.ADDR_W(32), .REG_OUT(1'b0)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_unsigned(req_unsigned), .mem_rdata(mem_rdata),
        .mem_word_addr(c_widx), .mem_be(c_be), .mem_wdata(c_wd),
        .ld_data(c_rd), .misalign(c_flt)
    );

    mem_lane_aligner #(.ADDR_W(32), .REG_OUT(1'b1)) uut_reg (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_unsigned(req_unsigned), .mem_rdata(mem_rdata),
        .mem_word_addr(r_widx), .mem_be(r_be), .mem_wdata(r_wd),
        .ld_data(r_rd), .misalign(r_flt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid    = 1'b1;
        req_we       = v.we;
        req_size     = v.sz;
        req_addr     = v.addr;
        req_wdata    = v.wd;
        req_unsigned = v.uns;
    endtask

    task automatic report;
        $display(" == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        // reset state of the registered variant: R11
        repeat (2) @(posedge clk);
        #1;
        chk("R11 reset be", {28'h0, r_be}, 32'h0);
        chk("R11 reset fault", {31'h0, r_flt}, 32'h0);
        chk("R11 reset ld_data", r_rd, 32'h0);
        chk("R11 reset widx", {2'b0, r_widx}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1;
            chk($sformatf("R%0d v%0d be", VECS[i].req, i), {28'h0, c_be}, {28'h0, VECS[i].ebe});
            chk($sformatf("R%0d v%0d fault", VECS[i].req, i), {31'h0, c_flt}, {31'h0, VECS[i].flt});
            chk($sformatf("R1 v%0d widx", i), {2'b0, c_widx}, {2'b0, VECS[i].addr[31:2]});
            if (VECS[i].we && !VECS[i].flt)
                chk($sformatf("R%0d v%0d wdata", VECS[i].req, i), c_wd, VECS[i].ewd);
            if (!VECS[i].we)
                chk($sformatf("R%0d v%0d ld_data", VECS[i].req, i), c_rd, VECS[i].erd);
        end

        // idle requests with misaligned fields: R10
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b1; req_size = 2'd2; req_addr = 32'h0000_0003;
        #1;
        chk("R10 idle be", {28'h0, c_be}, 32'h0);
        chk("R10 idle fault", {31'h0, c_flt}, 32'h0);

        // valid load never writes: R10
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_size = 2'd2; req_addr = 32'h0000_0010;
        #1;
        chk("R10 load be", {28'h0, c_be}, 32'h0);

        // registered latency: R11
        @(negedge clk);
        drive(VECS[5]);
        #1;
        chk("R11 before edge be", {28'h0, r_be}, 32'h0);
        @(posedge clk);
        #1;
        chk("R11 after edge be", {28'h0, r_be}, 32'hF);
        chk("R11 after edge wdata", r_wd, 32'hDEAD_BEEF);
        chk("R11 after edge widx", {2'b0, r_widx}, 32'h1);
        @(negedge clk);
        drive(VECS[13]);
        @(posedge clk);
        #1;
        chk("R11 registered load", r_rd, 32'hFFFF_80F1);
        chk("R11 registered no write", {28'h0, r_be}, 32'h0);

        done = 1'b1;
        report();
    end

endmodule